// File: doc/BRIEF.md
# Compound Branch Condition Evaluator

This block resolves a conditional jump. It compares two register values as signed numbers and takes one status flag chosen by the instruction. It merges the two results under a two-bit combine mode and decides whether the branch is taken. From that decision it produces the next program counter. A taken branch goes to the word stored after the instruction. That target is either absolute or relative to the current program counter, as the low opcode bit selects. A branch that is not taken steps the program counter past the target word.

The execute stage presents one branch per cycle with a valid strobe. The result is registered and appears on the following cycle. `cur_pc` is the address of the target word, which is the counter after the instruction word has been consumed. Producing the flags and fetching the target word are done outside this block.

Top module: `branch_resolve`

## Requirements
- R1: `cond[1:0]` selects the comparison of `val_a` against `val_b`, both read as two's-complement: 0 = equal, 1 = not equal, 2 = less than, 3 = less than or equal.
- R2: With `cond[1:0]` = 0, the comparison is true whenever `idx_a` equals `idx_b`, whatever the register values; the other comparison codes always use the values.
- R3: `cond[3:2]` selects the flag: 0 = `flag_ovf`, 1 = `flag_zero`, 2 = `flag_sign`, 3 = `flag_par`.
- R4: `cond[5:4]` selects the combine mode, with C the comparison and F the selected flag: 0 = C, 1 = C or F, 2 = C and not F, 3 = C or not F.
- R5: When taken with `rel_sel` = 0, `next_pc` equals `target_word`.
- R6: When taken with `rel_sel` = 1, `next_pc` equals `cur_pc + target_word`, truncated to XLEN bits.
- R7: When not taken, `next_pc` equals `cur_pc + 1`, truncated to XLEN bits (all ones wraps to zero).
- R8: A result is registered. The clock edge that samples `in_valid` high loads `taken` and `next_pc` and raises `out_valid` for exactly one cycle. On edges where `in_valid` is low, `out_valid` is low and `taken` and `next_pc` hold their values.
- R9: During reset, `out_valid`, `taken` and `next_pc` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A branch is presented this cycle |
| rel_sel | input | 1 | Low opcode bit: 1 adds `cur_pc` to the target |
| idx_a | input | IDXW | Register index of the first operand |
| idx_b | input | IDXW | Register index of the second operand |
| val_a | input | XLEN | First operand value |
| val_b | input | XLEN | Second operand value |
| cond | input | 6 | Comparison code [1:0], flag select [3:2], combine mode [5:4] |
| flag_ovf | input | 1 | Overflow flag |
| flag_zero | input | 1 | Zero flag |
| flag_sign | input | 1 | Sign flag |
| flag_par | input | 1 | Parity flag |
| cur_pc | input | XLEN | Address of the target word |
| target_word | input | XLEN | Word that follows the branch instruction |
| out_valid | output | 1 | Registered result is new this cycle |
| taken | output | 1 | Branch decision |
| next_pc | output | XLEN | Next program counter |

## Verification
The bench uses the defaults XLEN = 32 and IDXW = 5. At that width it can place operands on either side of the sign boundary, such as all ones against one, where a signed compare and an unsigned compare disagree. It can also put `cur_pc` close enough to the top of the address space that both the relative add and the plus-one step wrap. A five-bit index lets the bench present equal indices with differing values, which separates the index shortcut from a value compare.

// File: rtl/branch_resolve.sv
module branch_resolve #(
  parameter int XLEN = 32,
  parameter int IDXW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            rel_sel,
  input  logic [IDXW-1:0] idx_a,
  input  logic [IDXW-1:0] idx_b,
  input  logic [XLEN-1:0] val_a,
  input  logic [XLEN-1:0] val_b,
  input  logic [5:0]      cond,
  input  logic            flag_ovf,
  input  logic            flag_zero,
  input  logic            flag_sign,
  input  logic            flag_par,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] target_word,
  output logic            out_valid,
  output logic            taken,
  output logic [XLEN-1:0] next_pc
);

  localparam logic [1:0] CMP_EQ = 2'd0, CMP_NE = 2'd1, CMP_LT = 2'd2, CMP_LE = 2'd3;
  localparam logic [1:0] MIX_CMP = 2'd0, MIX_OR = 2'd1, MIX_ANDN = 2'd2, MIX_ORN = 2'd3;
  localparam logic [XLEN-1:0] STEP = XLEN'(1);

  logic cmp_hit, flag_bit, go;
  logic [XLEN-1:0] dest;

  wire signed [XLEN-1:0] sa = val_a;
  wire signed [XLEN-1:0] sb = val_b;

  always_comb begin
    case (cond[1:0])
      CMP_EQ:  cmp_hit = (idx_a == idx_b) || (val_a == val_b);
      CMP_NE:  cmp_hit = (val_a != val_b);
      CMP_LT:  cmp_hit = (sa < sb);
      default: cmp_hit = (sa <= sb);
    endcase
  end

  always_comb begin
    case (cond[3:2])
      2'd0:    flag_bit = flag_ovf;
      2'd1:    flag_bit = flag_zero;
      2'd2:    flag_bit = flag_sign;
      default: flag_bit = flag_par;
    endcase
  end

  always_comb begin
    case (cond[5:4])
      MIX_CMP:  go = cmp_hit;
      MIX_OR:   go = cmp_hit | flag_bit;
      MIX_ANDN: go = cmp_hit & ~flag_bit;
      default:  go = cmp_hit | ~flag_bit;
    endcase
  end

  assign dest = go ? (target_word + (rel_sel ? cur_pc : '0)) : (cur_pc + STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      next_pc   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken   <= go;
        next_pc <= dest;
      end
    end
  end

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(taken) && $stable(next_pc)));

  a_r2_same_index: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond == 6'd0 && idx_a == idx_b) |=> taken);

  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond == 6'd0 && idx_a != idx_b && val_a != val_b)
      |=> (!taken && next_pc == $past(cur_pc) + STEP));

  a_r5_absolute: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rel_sel) |=> (!taken || next_pc == $past(target_word)));

  a_r6_relative: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rel_sel) |=> (!taken || next_pc == $past(target_word) + $past(cur_pc)));

endmodule

// File: tb/tb_branch_resolve.sv
module tb_branch_resolve;
  localparam int CLK_NS = 10;
  localparam int XLEN = 32;
  localparam int IDXW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, rel_sel = 1'b0;
  logic [IDXW-1:0] idx_a = '0, idx_b = '0;
  logic [XLEN-1:0] val_a = '0, val_b = '0, cur_pc = '0, target_word = '0;
  logic [5:0] cond = '0;
  logic flag_ovf = 1'b0, flag_zero = 1'b0, flag_sign = 1'b0, flag_par = 1'b0;
  logic out_valid, taken;
  logic [XLEN-1:0] next_pc;

  int checks = 0;
  int failures = 0;

  always #(CLK_NS/2) clk = ~clk;

  branch_resolve #(.XLEN(XLEN), .IDXW(IDXW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rel_sel(rel_sel),
    .idx_a(idx_a), .idx_b(idx_b), .val_a(val_a), .val_b(val_b), .cond(cond),
    .flag_ovf(flag_ovf), .flag_zero(flag_zero), .flag_sign(flag_sign), .flag_par(flag_par),
    .cur_pc(cur_pc), .target_word(target_word),
    .out_valid(out_valid), .taken(taken), .next_pc(next_pc));

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // flags packed as {par, sign, zero, ovf}
  task automatic run(input logic rel, input logic [IDXW-1:0] ia, input logic [IDXW-1:0] ib,
                     input logic [XLEN-1:0] a, input logic [XLEN-1:0] b, input logic [5:0] c,
                     input logic [3:0] fl, input logic [XLEN-1:0] pc, input logic [XLEN-1:0] tgt);
    @(negedge clk);
    rel_sel = rel; idx_a = ia; idx_b = ib; val_a = a; val_b = b; cond = c;
    {flag_par, flag_sign, flag_zero, flag_ovf} = fl;
    cur_pc = pc; target_word = tgt; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_res(input string req, input logic exp_taken, input logic [XLEN-1:0] exp_pc);
    check({req, " valid"}, XLEN'(out_valid), XLEN'(1));
    check({req, " taken"}, XLEN'(taken), XLEN'(exp_taken));
    check({req, " pc"}, next_pc, exp_pc);
  endtask

  task automatic t_reset;
    check("R9 out_valid", XLEN'(out_valid), '0);
    check("R9 taken", XLEN'(taken), '0);
    check("R9 next_pc", next_pc, '0);
  endtask

  task automatic t_compare;
    run(0, 1, 2, 32'd7, 32'd7, 6'h00, 4'h0, 32'h100, 32'h40);
    expect_res("R1 eq equal", 1, 32'h40);
    run(0, 1, 2, 32'd7, 32'd8, 6'h00, 4'h0, 32'h100, 32'h40);
    expect_res("R1 eq differ R7", 0, 32'h101);
    run(0, 1, 2, 32'd7, 32'd8, 6'h01, 4'h0, 32'h100, 32'h40);
    expect_res("R1 ne", 1, 32'h40);
    run(0, 1, 2, 32'hFFFF_FFFF, 32'd1, 6'h02, 4'h0, 32'h100, 32'h40);
    expect_res("R1 lt signed neg", 1, 32'h40);
    run(0, 1, 2, 32'd1, 32'hFFFF_FFFF, 32'h02, 4'h0, 32'h100, 32'h40);
    expect_res("R1 lt signed pos", 0, 32'h101);
    run(0, 1, 2, 32'd5, 32'd5, 6'h02, 4'h0, 32'h100, 32'h40);
    expect_res("R1 lt equal", 0, 32'h101);
    run(0, 1, 2, 32'd5, 32'd5, 6'h03, 4'h0, 32'h100, 32'h40);
    expect_res("R1 le equal", 1, 32'h40);
    run(0, 1, 2, 32'h8000_0000, 32'h7FFF_FFFF, 6'h03, 4'h0, 32'h100, 32'h40);
    expect_res("R1 le min", 1, 32'h40);
  endtask

  task automatic t_same_index;
    run(0, 9, 9, 32'd3, 32'd4, 6'h00, 4'h0, 32'h200, 32'h55);
    expect_res("R2 same idx eq", 1, 32'h55);
    run(0, 9, 9, 32'd3, 32'd4, 6'h01, 4'h0, 32'h200, 32'h55);
    expect_res("R2 same idx ne uses values", 1, 32'h55);
    run(0, 9, 9, 32'd4, 32'd3, 6'h02, 4'h0, 32'h200, 32'h55);
    expect_res("R2 same idx lt uses values", 0, 32'h201);
  endtask

  task automatic t_flags;
    for (int s = 0; s < 4; s++) begin
      // compare false (ne on equal values), mode OR: result follows the flag
      run(0, 1, 2, 32'd1, 32'd1, {2'd1, 2'(s), 2'd1}, 4'(1 << s), 32'h300, 32'h77);
      expect_res("R3 selected flag set", 1, 32'h77);
      run(0, 1, 2, 32'd1, 32'd1, {2'd1, 2'(s), 2'd1}, 4'hF & ~4'(1 << s), 32'h300, 32'h77);
      expect_res("R3 other flags set", 0, 32'h301);
    end
  endtask

  task automatic t_combine;
    // zero flag selected (cond[3:2]=1); compare eq on values
    run(0, 1, 2, 32'd1, 32'd2, 6'h04, 4'h2, 32'h400, 32'h88);
    expect_res("R4 mode0 ignores flag", 0, 32'h401);
    run(0, 1, 2, 32'd1, 32'd1, 6'h24, 4'h0, 32'h400, 32'h88);
    expect_res("R4 and-not flag clear", 1, 32'h88);
    run(0, 1, 2, 32'd1, 32'd1, 6'h24, 4'h2, 32'h400, 32'h88);
    expect_res("R4 and-not flag set", 0, 32'h401);
    run(0, 1, 2, 32'd1, 32'd2, 6'h34, 4'h0, 32'h400, 32'h88);
    expect_res("R4 or-not flag clear", 1, 32'h88);
    run(0, 1, 2, 32'd1, 32'd2, 6'h34, 4'h2, 32'h400, 32'h88);
    expect_res("R4 or-not flag set", 0, 32'h401);
  endtask

  task automatic t_targets;
    run(0, 1, 1, 0, 0, 6'h00, 4'h0, 32'h1000, 32'h20);
    expect_res("R5 absolute", 1, 32'h20);
    run(1, 1, 1, 0, 0, 6'h00, 4'h0, 32'h1000, 32'h20);
    expect_res("R6 relative", 1, 32'h1020);
    run(1, 1, 1, 0, 0, 6'h00, 4'h0, 32'hFFFF_FFF0, 32'h20);
    expect_res("R6 relative wrap", 1, 32'h10);
    run(1, 1, 2, 1, 2, 6'h00, 4'h0, 32'hFFFF_FFFF, 32'h20);
    expect_res("R7 step wrap", 0, 32'h0);
  endtask

  task automatic t_hold;
    run(1, 1, 1, 0, 0, 6'h00, 4'h0, 32'h50, 32'h5);
    expect_res("R8 load", 1, 32'h55);
    @(negedge clk);
    rel_sel = 0; cond = 6'h01; val_a = 1; val_b = 1; idx_a = 3; idx_b = 4; cur_pc = 32'h9000;
    repeat (3) @(negedge clk);
    check("R8 valid low", XLEN'(out_valid), '0);
    check("R8 taken held", XLEN'(taken), XLEN'(1));
    check("R8 pc held", next_pc, 32'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_compare();
    t_same_index();
    t_flags();
    t_combine();
    t_targets();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_NS * 20000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule